// File: doc/BRIEF.md
# Compact Register-Mapped Serial Port

This block is a small asynchronous serial port that a processor reaches through a 16-byte window of four 32-bit word registers. The bus side has a word address, single-cycle read and write strobes, write data and read data that is combinational while the read strobe is high. A 16-entry transmit queue feeds a serializer that sends one fixed frame format. An oversampling receiver feeds a 16-entry receive queue. The bit time is a build-time clock count per bit.

Software learns the block's state from one status word and controls it through one control word. The control word empties either queue, and it also sets or clears a single interrupt enable. The interrupt line is a one-cycle event, not a level that waits for service. It fires when the receive queue stops being empty, or when the transmit queue runs dry after having held data. Receive errors are kept as sticky status flags, and reading the status word clears them.

Top module: `lite_uart`

## Requirements
- R1: After reset the status word reads 0x04: only the transmit-empty bit (bit 2) is set. The interrupt line is low and the serial output is high.
- R2: A write to offset 0x4 queues bits 7:0 of the write data, and bits above 7 are ignored. Each byte goes out as a low start bit, eight data bits least significant first, an even parity bit (the XOR of the data bits) and a high stop bit. Every bit lasts CLKS_PER_BIT clocks.
- R3: The transmit queue holds 16 bytes. Status bit 3 is set while it is full, and a write to offset 0x4 while it is full is dropped.
- R4: Writing control (offset 0xC) with bit 0 set empties the transmit queue, so status bit 2 reads 1 on the next access. A frame already on the line still completes.
- R5: A correctly framed byte on the serial input enters the receive queue and sets status bit 0. A read of offset 0x0 returns the oldest byte in bits 7:0 and removes it.
- R6: A read of offset 0x0 while the receive queue is empty returns zero and leaves the status unchanged.
- R7: The receive queue holds 16 bytes, and status bit 1 is set while it is full. A byte that arrives while it is full is discarded and sets status bit 5 (overrun).
- R8: A stop bit sampled low sets status bit 6, and a parity mismatch sets status bit 7; the byte is still queued in both cases. Bits 5, 6 and 7 stay set until the status word (offset 0x8) is read.
- R9: Writing control with bit 1 set empties the receive queue.
- R10: Control bit 4 is the interrupt enable, and status bit 4 reads it back. Any control write with bit 4 clear disables interrupts.
- R11: While interrupts are enabled, the interrupt line goes high for exactly one clock when the receive queue goes from empty to non-empty. Further arrivals into a non-empty queue raise no new event.
- R12: While interrupts are enabled, the interrupt line goes high for one clock when the transmit queue becomes empty after holding data. While interrupts are disabled the line stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW | Byte address; bits 3:2 select the word register |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | DW | Write data |
| bus_rd | input | 1 | Single-cycle read strobe; a receive read removes a byte at the clock edge |
| bus_rdata | output | DW | Read data, valid while bus_rd is high, zero otherwise |
| irq | output | 1 | One-cycle interrupt event |
| txd | output | 1 | Serial output, high when idle |
| rxd | input | 1 | Serial input, synchronized inside |

## Verification
A queue level that drifts from the true count shows up at the ports: the full and empty status bits come out wrong, a dropped or doubled byte appears in the serial stream, or a received byte is read out of order. Each of these is visible at the next status or data read. A serializer or receiver out of step corrupts the framing of the very next byte, and this shows as a wrong value, a wrong parity bit or a stop bit that is not high. A wrong queue-empty history becomes visible within one clock, as a missing interrupt pulse, an extra pulse or a pulse longer than one cycle. For that reason the bench counts interrupt cycles on every clock and checks them against its own model.

// File: rtl/lu_pkg.sv
package lu_pkg;
   // word index of each register inside the 16-byte window
   localparam int unsigned REG_RX   = 0;
   localparam int unsigned REG_TX   = 1;
   localparam int unsigned REG_STAT = 2;
   localparam int unsigned REG_CTRL = 3;

   // status bit positions
   localparam int unsigned ST_RXVLD   = 0;
   localparam int unsigned ST_RXFULL  = 1;
   localparam int unsigned ST_TXEMPTY = 2;
   localparam int unsigned ST_TXFULL  = 3;
   localparam int unsigned ST_IE      = 4;
   localparam int unsigned ST_OVR     = 5;
   localparam int unsigned ST_FRM     = 6;
   localparam int unsigned ST_PAR     = 7;

   // control bit positions
   localparam int unsigned CT_TXRST = 0;
   localparam int unsigned CT_RXRST = 1;
   localparam int unsigned CT_IE    = 4;

   typedef enum logic [2:0] {
      LINE_IDLE,
      LINE_START,
      LINE_DATA,
      LINE_PAR,
      LINE_STOP
   } line_state_e;

   typedef enum logic [1:0] {
      PAR_NONE,
      PAR_EVEN,
      PAR_ODD
   } par_mode_e;

   function automatic logic par_of(input logic [7:0] d, input par_mode_e m);
      return (m == PAR_ODD) ? ~(^d) : (^d);
   endfunction
endpackage

// File: rtl/lu_fifo.sv
module lu_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           flush,
   input  logic                           push,
   input  logic [WIDTH-1:0]               din,
   input  logic                           pop,
   output logic [WIDTH-1:0]               dout,
   output logic                           empty,
   output logic                           full,
   output logic [$clog2(DEPTH+1)-1:0]     level
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("lu_fifo: DEPTH must be a power of two of at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("lu_fifo: WIDTH must be positive");
      end
   endgenerate

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wr_ptr, rd_ptr;
   logic [CW-1:0]    cnt;
   logic             do_push, do_pop;

   assign empty   = (cnt == '0);
   assign full    = (cnt == CW'(DEPTH));
   assign level   = cnt;
   assign dout    = mem[rd_ptr];
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);

   always_ff @(posedge clk) begin
      if (do_push && !flush) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt    <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + AW'(1);
         if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
         cnt <= cnt + CW'(do_push) - CW'(do_pop);
      end
   end

   // the level never exceeds the capacity
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      level <= CW'(DEPTH));
   // a flush leaves the queue empty on the next cycle (R4, R9)
   assert_flush_empties_R4: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);
endmodule

// File: rtl/lu_txser.sv
module lu_txser
   import lu_pkg::*;
#(
   parameter int        CPB    = 8,
   parameter par_mode_e PARITY = PAR_EVEN
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [7:0] byte_in,
   output logic       ready,
   output logic       txd
);
   localparam int CW      = (CPB > 1) ? $clog2(CPB) : 1;
   localparam bit HAS_PAR = (PARITY != PAR_NONE);

   generate
      if (CPB < 4) begin : g_bad_cpb
         $error("lu_txser: CPB must be at least 4");
      end
   endgenerate

   line_state_e state;
   logic [CW-1:0] cnt;
   logic [2:0]    bit_n;
   logic [7:0]    sh;
   logic          pb;
   logic          tick;

   assign tick  = (cnt == CW'(CPB - 1));
   assign ready = (state == LINE_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= LINE_IDLE;
         cnt   <= '0;
         bit_n <= '0;
         sh    <= '0;
         pb    <= 1'b0;
      end else if (state == LINE_IDLE) begin
         if (go) begin
            sh    <= byte_in;
            pb    <= par_of(byte_in, PARITY);
            state <= LINE_START;
            cnt   <= '0;
         end
      end else begin
         cnt <= tick ? '0 : cnt + CW'(1);
         if (tick) begin
            unique case (state)
               LINE_START: begin
                  state <= LINE_DATA;
                  bit_n <= '0;
               end
               LINE_DATA: begin
                  sh    <= {1'b0, sh[7:1]};
                  bit_n <= bit_n + 3'd1;
                  if (bit_n == 3'd7) state <= HAS_PAR ? LINE_PAR : LINE_STOP;
               end
               LINE_PAR:  state <= LINE_STOP;
               LINE_STOP: state <= LINE_IDLE;
               default:   state <= LINE_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      unique case (state)
         LINE_START: txd = 1'b0;
         LINE_DATA:  txd = sh[0];
         LINE_PAR:   txd = pb;
         default:    txd = 1'b1;
      endcase
   end

   // an accepted byte starts its frame with a low start bit
   assert_frame_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (go && ready) |=> !txd);
endmodule

// File: rtl/lu_rxser.sv
module lu_rxser
   import lu_pkg::*;
#(
   parameter int        CPB    = 8,
   parameter par_mode_e PARITY = PAR_EVEN
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rxd,
   output logic       out_valid,
   output logic [7:0] out_byte,
   output logic       out_perr,
   output logic       out_ferr
);
   localparam int CW      = (CPB > 1) ? $clog2(CPB) : 1;
   localparam int HALF    = CPB / 2;
   localparam bit HAS_PAR = (PARITY != PAR_NONE);

   generate
      if (CPB < 4) begin : g_bad_cpb
         $error("lu_rxser: CPB must be at least 4");
      end
   endgenerate

   logic s1, s2, s3;
   line_state_e state;
   logic [CW-1:0] cnt;
   logic [2:0]    bit_n;
   logic [7:0]    sh;
   logic          perr_r;
   logic          perr_q;
   logic          tick;

   assign tick = (cnt == CW'(CPB - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s1 <= 1'b1;
         s2 <= 1'b1;
         s3 <= 1'b1;
      end else begin
         s1 <= rxd;
         s2 <= s1;
         s3 <= s2;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state     <= LINE_IDLE;
         cnt       <= '0;
         bit_n     <= '0;
         sh        <= '0;
         perr_r    <= 1'b0;
         out_valid <= 1'b0;
         out_byte  <= '0;
         out_ferr  <= 1'b0;
         perr_q    <= 1'b0;
      end else begin
         out_valid <= 1'b0;
         unique case (state)
            LINE_IDLE: begin
               cnt <= '0;
               if (s3 && !s2) state <= LINE_START;
            end
            LINE_START: begin
               if (cnt == CW'(HALF - 1)) begin
                  cnt    <= '0;
                  bit_n  <= '0;
                  perr_r <= 1'b0;
                  state  <= s2 ? LINE_IDLE : LINE_DATA;
               end else begin
                  cnt <= cnt + CW'(1);
               end
            end
            LINE_DATA: begin
               cnt <= tick ? '0 : cnt + CW'(1);
               if (tick) begin
                  sh    <= {s2, sh[7:1]};
                  bit_n <= bit_n + 3'd1;
                  if (bit_n == 3'd7) state <= HAS_PAR ? LINE_PAR : LINE_STOP;
               end
            end
            LINE_PAR: begin
               cnt <= tick ? '0 : cnt + CW'(1);
               if (tick) begin
                  perr_r <= (s2 != par_of(sh, PARITY));
                  state  <= LINE_STOP;
               end
            end
            LINE_STOP: begin
               cnt <= tick ? '0 : cnt + CW'(1);
               if (tick) begin
                  out_valid <= 1'b1;
                  out_byte  <= sh;
                  out_ferr  <= !s2;
                  perr_q    <= perr_r;
                  state     <= LINE_IDLE;
               end
            end
            default: state <= LINE_IDLE;
         endcase
      end
   end

   generate
      if (HAS_PAR) begin : g_par
         assign out_perr = perr_q;
      end else begin : g_nopar
         assign out_perr = 1'b0;
      end
   endgenerate

   // a received byte is announced for a single cycle
   assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);
endmodule

// File: rtl/lite_uart.sv
module lite_uart
   import lu_pkg::*;
#(
   parameter int        DW            = 32,
   parameter int        AW            = 4,
   parameter int        FIFO_DEPTH    = 16,
   parameter int        CLKS_PER_BIT  = 8,
   parameter par_mode_e PARITY        = PAR_EVEN
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] bus_addr,
   input  logic          bus_wr,
   input  logic [DW-1:0] bus_wdata,
   input  logic          bus_rd,
   output logic [DW-1:0] bus_rdata,
   output logic          irq,
   output logic          txd,
   input  logic          rxd
);
   localparam int LW = $clog2(FIFO_DEPTH + 1);

   generate
      if (DW < 8) begin : g_bad_dw
         $error("lite_uart: DW must be at least 8");
      end
      if (AW < 4) begin : g_bad_aw
         $error("lite_uart: AW must cover the 16-byte window");
      end
   endgenerate

   logic [1:0] word;
   logic       rx_rd, tx_wr, stat_rd, ctrl_wr;
   assign word    = bus_addr[3:2];
   assign rx_rd   = bus_rd && (word == 2'(REG_RX));
   assign stat_rd = bus_rd && (word == 2'(REG_STAT));
   assign tx_wr   = bus_wr && (word == 2'(REG_TX));
   assign ctrl_wr = bus_wr && (word == 2'(REG_CTRL));

   // transmit path
   logic          tx_flush, tx_empty, tx_full, tx_ready, tx_go;
   logic [7:0]    tx_head;
   logic [LW-1:0] tx_level;
   assign tx_flush = ctrl_wr && bus_wdata[CT_TXRST];
   assign tx_go    = tx_ready && !tx_empty;

   lu_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .flush(tx_flush),
      .push(tx_wr), .din(bus_wdata[7:0]), .pop(tx_go),
      .dout(tx_head), .empty(tx_empty), .full(tx_full), .level(tx_level)
   );

   lu_txser #(.CPB(CLKS_PER_BIT), .PARITY(PARITY)) u_tx (
      .clk(clk), .rst_n(rst_n), .go(tx_go), .byte_in(tx_head),
      .ready(tx_ready), .txd(txd)
   );

   // receive path
   logic          rx_flush, rx_empty, rx_full;
   logic          rx_valid, rx_perr, rx_ferr;
   logic [7:0]    rx_byte, rx_head;
   logic [LW-1:0] rx_level;
   assign rx_flush = ctrl_wr && bus_wdata[CT_RXRST];

   lu_rxser #(.CPB(CLKS_PER_BIT), .PARITY(PARITY)) u_rx (
      .clk(clk), .rst_n(rst_n), .rxd(rxd), .out_valid(rx_valid),
      .out_byte(rx_byte), .out_perr(rx_perr), .out_ferr(rx_ferr)
   );

   lu_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .flush(rx_flush),
      .push(rx_valid), .din(rx_byte), .pop(rx_rd),
      .dout(rx_head), .empty(rx_empty), .full(rx_full), .level(rx_level)
   );

   // sticky flags and enable
   logic ie_q, ovr_q, frm_q, par_q;
   logic ovr_set, frm_set, par_set;
   assign ovr_set = rx_valid && rx_full && !rx_rd;
   assign frm_set = rx_valid && rx_ferr;
   assign par_set = rx_valid && rx_perr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q  <= 1'b0;
         ovr_q <= 1'b0;
         frm_q <= 1'b0;
         par_q <= 1'b0;
      end else begin
         if (ctrl_wr) ie_q <= bus_wdata[CT_IE];
         ovr_q <= ovr_set || (ovr_q && !stat_rd);
         frm_q <= frm_set || (frm_q && !stat_rd);
         par_q <= par_set || (par_q && !stat_rd);
      end
   end

   // interrupt events from queue-empty history
   logic rx_empty_q, tx_empty_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_empty_q <= 1'b1;
         tx_empty_q <= 1'b1;
      end else begin
         rx_empty_q <= rx_empty;
         tx_empty_q <= tx_empty;
      end
   end
   assign irq = ie_q && ((rx_empty_q && !rx_empty) || (!tx_empty_q && tx_empty));

   // read data
   logic [7:0] stat;
   always_comb begin
      stat             = '0;
      stat[ST_RXVLD]   = !rx_empty;
      stat[ST_RXFULL]  = rx_full;
      stat[ST_TXEMPTY] = tx_empty;
      stat[ST_TXFULL]  = tx_full;
      stat[ST_IE]      = ie_q;
      stat[ST_OVR]     = ovr_q;
      stat[ST_FRM]     = frm_q;
      stat[ST_PAR]     = par_q;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         unique case (word)
            2'(REG_RX):   bus_rdata = DW'(rx_empty ? 8'h00 : rx_head);
            2'(REG_STAT): bus_rdata = DW'(stat);
            default:      bus_rdata = '0;
         endcase
      end
   end

   // a write into a full transmit queue leaves it full and unchanged
   assert_tx_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && tx_full && !tx_go) |=> (tx_full && $stable(tx_level)));
   // a read of the empty receive queue changes nothing there
   assert_empty_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && rx_empty && !rx_valid) |=> rx_empty);
   // arrival into a full receive queue raises the overrun flag
   assert_overrun_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_full && !rx_rd && !rx_flush) |=> (ovr_q && rx_full));
   // a status read with no new error clears every sticky flag
   assert_sticky_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !rx_valid) |=> (!ovr_q && !frm_q && !par_q));
   // the enable follows the last control write
   assert_ie_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> (ie_q == $past(bus_wdata[CT_IE])));
   // the first arrival into an empty queue raises the interrupt
   assert_rx_event_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ie_q && !ctrl_wr && rx_empty && rx_valid && !rx_flush) |=> irq);
   // a queue that runs dry raises the interrupt when enabled
   assert_tx_event_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (ie_q && !ctrl_wr && tx_level == LW'(1) && tx_go && !tx_wr) |=> irq);
endmodule

// File: tb/tb_lite_uart.sv
module tb_lite_uart;
   localparam int CPB   = 8;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic        bus_rd = 1'b0;
   logic [31:0] bus_rdata;
   logic        irq, txd;
   logic        rxd = 1'b1;

   always #4 clk = ~clk;

   lite_uart dut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
      .irq(irq), .txd(txd), .rxd(rxd)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   // behavioural model state
   bit   m_ie = 1'b0;
   int   irq_cycles = 0;
   logic [7:0] mon_q[$];
   int   mon_bad = 0;
   logic [7:0] exp_tx[$];

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      if (a == 4'hC) m_ie = d[4];
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(input logic [7:0] b, input bit bad_par, input bit bad_stop);
      @(negedge clk);
      rxd = 1'b0;
      idle(CPB);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         idle(CPB);
      end
      rxd = (^b) ^ bad_par;
      idle(CPB);
      rxd = !bad_stop;
      idle(CPB);
      rxd = 1'b1;
      idle(2 * CPB);
   endtask

   // per-clock model comparison of the interrupt line
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_chk++;
         if (irq && !m_ie) begin
            n_fail++;
            $display("FAIL R12 irq high while disabled actual=1 expected=0");
         end
         if (irq) irq_cycles++;
      end
   end

   // behavioural decoder of the serial output
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && txd === 1'b0) begin
            logic [7:0] b;
            logic ok;
            idle(CPB / 2);
            ok = (txd === 1'b0);
            for (int i = 0; i < 8; i++) begin
               idle(CPB);
               b[i] = txd;
            end
            idle(CPB);
            if (txd !== ^b) ok = 1'b0;
            idle(CPB);
            if (txd !== 1'b1) ok = 1'b0;
            if (!ok) mon_bad++;
            mon_q.push_back(b);
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      int base;
      idle(5);
      rst_n = 1'b1;

      // R1 reset state
      rd(4'h8, v);
      check("R1 status after reset", v, 32'h4);
      check("R1 irq after reset", {31'b0, irq}, 32'h0);
      check("R1 txd idle", {31'b0, txd}, 32'h1);

      // R2 upper bits ignored, frame format and parity
      wr(4'h4, 32'h0000_01A5); exp_tx.push_back(8'hA5);
      wr(4'h4, 32'hFFFF_FF3C); exp_tx.push_back(8'h3C);
      wr(4'h4, 32'h0000_0281); exp_tx.push_back(8'h81);
      idle(4 * 11 * CPB);
      check("R2 bytes sent", mon_q.size(), 3);
      for (int i = 0; i < 3 && i < mon_q.size(); i++)
         check("R2 serial byte", mon_q[i], exp_tx[i]);
      check("R2 frame errors on line", mon_bad, 0);

      // R3 queue capacity and dropped write
      base = mon_q.size();
      exp_tx.delete();
      for (int i = 0; i < 17; i++) begin
         wr(4'h4, 32'(8'(i * 7 + 1)));
         exp_tx.push_back(8'(i * 7 + 1));
      end
      rd(4'h8, v);
      check("R3 status full", v & 32'hC, 32'h8);
      wr(4'h4, 32'hEE);
      idle(19 * 11 * CPB);
      check("R3 count sent", mon_q.size() - base, 17);
      for (int i = 0; i < 17 && base + i < mon_q.size(); i++)
         check("R3 serial order", mon_q[base + i], exp_tx[i]);
      rd(4'h8, v);
      check("R3 drained status", v, 32'h4);

      // R4 transmit reset
      base = mon_q.size();
      for (int i = 0; i < 5; i++) wr(4'h4, 32'(8'h60 + i));
      wr(4'hC, 32'h1);
      rd(4'h8, v);
      check("R4 tx empty after reset", v, 32'h4);
      idle(7 * 11 * CPB);
      check("R4 only in-flight byte sent", mon_q.size() - base, 1);
      if (mon_q.size() > base) check("R4 in-flight byte", mon_q[base], 8'h60);

      // R5 basic receive
      send_frame(8'h5A, 0, 0);
      rd(4'h8, v);
      check("R5 rx valid", v, 32'h5);
      rd(4'h0, v);
      check("R5 rx byte", v, 32'h5A);
      rd(4'h8, v);
      check("R5 status after pop", v, 32'h4);

      // R6 empty read
      rd(4'h0, v);
      check("R6 empty read data", v, 32'h0);
      rd(4'h8, v);
      check("R6 status unchanged", v, 32'h4);

      // R8 parity and framing, sticky until status read
      send_frame(8'h33, 1, 0);
      rd(4'h8, v);
      check("R8 parity flag", v, 32'h85);
      rd(4'h8, v);
      check("R8 parity cleared by read", v, 32'h05);
      rd(4'h0, v);
      check("R8 byte kept after parity error", v, 32'h33);
      send_frame(8'h0F, 0, 1);
      rd(4'h8, v);
      check("R8 framing flag", v, 32'h45);
      rd(4'h8, v);
      check("R8 framing cleared by read", v, 32'h05);
      rd(4'h0, v);
      check("R8 byte kept after framing error", v, 32'h0F);

      // R9 receive reset
      send_frame(8'h11, 0, 0);
      send_frame(8'h22, 0, 0);
      wr(4'hC, 32'h2);
      rd(4'h8, v);
      check("R9 rx empty after reset", v, 32'h4);
      rd(4'h0, v);
      check("R9 read after reset", v, 32'h0);

      // R7 receive capacity and overrun
      for (int i = 0; i < 16; i++) send_frame(8'(8'h40 + i), 0, 0);
      rd(4'h8, v);
      check("R7 rx full", v, 32'h07);
      send_frame(8'hC3, 0, 0);
      rd(4'h8, v);
      check("R7 overrun flag", v, 32'h27);
      rd(4'h8, v);
      check("R7 overrun cleared", v, 32'h07);
      for (int i = 0; i < 16; i++) begin
         rd(4'h0, v);
         check("R7 queued byte order", v, 32'(8'h40 + i));
      end
      rd(4'h8, v);
      check("R7 drained", v, 32'h4);

      // R10 enable readback
      wr(4'hC, 32'h10);
      rd(4'h8, v);
      check("R10 ie reported", v, 32'h14);

      // R11 one pulse on first arrival only
      irq_cycles = 0;
      send_frame(8'h77, 0, 0);
      send_frame(8'h78, 0, 0);
      check("R11 irq cycles for two arrivals", irq_cycles, 1);
      rd(4'h0, v);
      check("R11 first byte", v, 32'h77);
      rd(4'h0, v);
      check("R11 second byte", v, 32'h78);

      // R12 transmit empty event, then disabled
      irq_cycles = 0;
      wr(4'h4, 32'h55);
      idle(12 * CPB);
      check("R12 irq on tx empty", irq_cycles, 1);
      wr(4'hC, 32'h0);
      rd(4'h8, v);
      check("R10 ie cleared", v, 32'h4);
      irq_cycles = 0;
      wr(4'h4, 32'h66);
      send_frame(8'h12, 0, 0);
      idle(12 * CPB);
      check("R12 no irq when disabled", irq_cycles, 0);
      rd(4'h0, v);
      check("R5 byte while disabled", v, 32'h12);
      check("R2 line clean", mon_bad, 0);

      finish_run();
   end
endmodule